// File: doc/BRIEF.md
# Triggered Circular Trace Capture Controller

This block controls a circular trace store on chip. While capture is running, every valid trace word is written to the next slot of an external RAM through a one-cycle write strobe. The write pointer wraps modulo a power-of-two depth. A sticky wrap flag tells software whether the oldest valid entry sits at the write pointer (wrapped) or at slot zero (not wrapped, so only slots 0 to pointer-1 are valid).

A trigger strobe does not stop capture at once. It loads a post-trigger down counter from a programmed count, and capture goes on for that many further stored words. The stored window can therefore straddle the trigger point. When the count is used up, writing stops and an acquisition-complete flag rises. A drain-done flag follows after a fixed two-cycle drain.

Software drives the block through register-style strobes: a control write (run bit and port-split bit), a post-trigger count load and a write-pointer load.

The controller is a state machine with five states:
- `ST_IDLE`: stopped.
- `ST_PRE`: capturing, waiting for the trigger.
- `ST_POST`: capturing, counting down after the trigger.
- `ST_DRAIN`: writing stopped, drain delay running.
- `ST_DONE`: drained.

Its transitions are:
- start: a control write with run=1 moves any state to `ST_PRE`.
- stop: a control write with run=0 moves any state to `ST_IDLE`.
- trigger: `ST_PRE` moves to `ST_POST`, or straight to `ST_DRAIN` when the count is zero.
- count-out: `ST_POST` moves to `ST_DRAIN` on the last counted word.
- drain-out: `ST_DRAIN` moves to `ST_DONE` after two cycles.

Top module: `trace_capture_ctl`

## Requirements
- R1: After reset the status is 0, the write pointer is 0, `ram_we` is 0 and the block is stopped.
- R2: A control write with bit 0 set starts capture and clears all four status bits. The write pointer is not changed by it.
- R3: While capturing (`ST_PRE` or `ST_POST`), a cycle with `trace_valid` high and no control write drives `ram_we` high in that same cycle, with `ram_addr` equal to the write pointer. The pointer then advances by one at the clock edge, wrapping modulo 2^DEPTH_LOG2. In any other state `ram_we` stays low and the pointer holds.
- R4: Status bit 0 (wrapped) is set by a store at the last address (all ones). It stays set until the next start.
- R5: Status bit 1 (triggered) is set by the first `trigger_in` seen in `ST_PRE`. Later triggers, and triggers outside capture, have no effect.
- R6: With post-trigger count N loaded, the word stored in the trigger cycle is not counted, and exactly N more valid words are stored. Writing stops with the Nth, and status bit 2 (acquisition complete) is set at that edge. With N=0, capture ends at the trigger edge itself.
- R7: Status bit 3 (drained) rises exactly two cycles after status bit 2 rises, and no word is stored in between.
- R8: A control write with bit 0 clear stops capture from that cycle on and leaves the status bits as they were.
- R9: A write-pointer load takes priority over the increment in the same cycle. A post-trigger count load sets the count used by the next trigger.
- R10: Control bit 1 selects split-port mode. In that mode `ram_wdata` carries the whole 2*PORT_W input word. Otherwise the upper PORT_W bits are zero. The mode is honoured only when PORT_W is 8; for any other width it is forced off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Bit 0 run, bit 1 split-port mode |
| tcnt_we | input | 1 | Post-trigger count load strobe |
| tcnt_wdata | input | CNT_W | Post-trigger word count |
| wptr_we | input | 1 | Write-pointer load strobe |
| wptr_wdata | input | DEPTH_LOG2 | Write-pointer load value |
| trace_valid | input | 1 | Trace word valid |
| trace_data | input | 2*PORT_W | Trace word |
| trigger_in | input | 1 | Trigger strobe |
| status | output | 4 | {drained, acq complete, triggered, wrapped} |
| wptr | output | DEPTH_LOG2 | Current write pointer |
| post_left | output | CNT_W | Words still to capture after the trigger |
| demux_on | output | 1 | Split-port mode active |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | DEPTH_LOG2 | RAM write address |
| ram_wdata | output | 2*PORT_W | RAM write data |

## Verification
A per-cycle vector table runs one full acquisition. Valid words arrive with gaps, a trigger lands on a valid word, and a second trigger lands mid-countdown. This tells a correct post-trigger count apart from one that counts idle cycles, counts the trigger word, or reloads on a repeat trigger. Valid words that keep arriving after completion, during the drain and after it, show that writing really stops. A second run starts from a non-zero pointer and crosses the wrap, which separates the wrapped flag from a plain pointer compare. A stop in mid-run and an idle trigger show that flags are preserved and triggers are ignored outside capture. Directed cases cover a zero post-trigger count, a pointer load colliding with a store, and the data path in both port modes.

// File: rtl/trc_pkg.sv
package trc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_POST,
        ST_DRAIN,
        ST_DONE
    } trc_state_e;

    // status bit positions are decoded by software
    localparam int unsigned SB_WRAP = 0;
    localparam int unsigned SB_TRIG = 1;
    localparam int unsigned SB_ACQ  = 2;
    localparam int unsigned SB_DRN  = 3;
endpackage

// File: rtl/trc_wptr.sv
module trc_wptr #(
    parameter int unsigned AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic          wrap_hit
);
    localparam logic [AW-1:0] LAST = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    ptr <= '0;
        else if (load) ptr <= load_val;
        else if (step) ptr <= ptr + 1'b1;
    end

    assign wrap_hit = step && (ptr == LAST);
endmodule

// File: rtl/trc_post_cnt.sv
module trc_post_cnt #(
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [CW-1:0] cfg_val,
    input  logic          arm,
    input  logic          dec,
    output logic [CW-1:0] remain,
    output logic          last,
    output logic          cfg_zero
);
    logic [CW-1:0] cfg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       remain <= '0;
        else if (arm)                     remain <= cfg_q;
        else if (dec && remain != '0)     remain <= remain - 1'b1;
    end

    assign last     = (remain == CW'(1));
    assign cfg_zero = (cfg_q == '0);
endmodule

// File: rtl/trc_fsm.sv
module trc_fsm
    import trc_pkg::*;
#(
    parameter int unsigned DRAIN_CYC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_we,
    input  logic       run_bit,
    input  logic       trigger,
    input  logic       store,
    input  logic       cfg_zero,
    input  logic       last,
    input  logic       wrap_hit,
    output logic       capturing,
    output logic       arm_post,
    output logic       post_dec,
    output logic [3:0] status
);
    localparam int unsigned DW = $clog2(DRAIN_CYC) + 1;
    localparam logic [DW-1:0] DRAIN_END = DW'(DRAIN_CYC - 1);

    trc_state_e    state, nxt;
    logic [DW-1:0] drain_cnt;

    always_comb begin
        nxt = state;
        if (ctl_we) begin
            nxt = run_bit ? ST_PRE : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:  nxt = ST_IDLE;
                ST_PRE:   if (trigger) nxt = cfg_zero ? ST_DRAIN : ST_POST;
                ST_POST:  if (store && last) nxt = ST_DRAIN;
                ST_DRAIN: if (drain_cnt == DRAIN_END) nxt = ST_DONE;
                ST_DONE:  nxt = ST_DONE;
                default:  nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    assign capturing = (state == ST_PRE) || (state == ST_POST);
    assign arm_post  = (state == ST_PRE) && trigger && !ctl_we;
    assign post_dec  = (state == ST_POST) && store;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status    <= '0;
            drain_cnt <= '0;
        end else if (ctl_we && run_bit) begin
            status    <= '0;
            drain_cnt <= '0;
        end else begin
            if (wrap_hit) status[SB_WRAP] <= 1'b1;
            if (arm_post) status[SB_TRIG] <= 1'b1;
            if (nxt == ST_DRAIN && state != ST_DRAIN) begin
                status[SB_ACQ] <= 1'b1;
                drain_cnt      <= '0;
            end else if (state == ST_DRAIN) begin
                drain_cnt <= drain_cnt + 1'b1;
            end
            if (state == ST_DRAIN && nxt == ST_DONE) status[SB_DRN] <= 1'b1;
        end
    end
endmodule

// File: rtl/trace_capture_ctl.sv
module trace_capture_ctl #(
    parameter int unsigned DEPTH_LOG2 = 4,
    parameter int unsigned PORT_W     = 8,
    parameter int unsigned CNT_W      = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  ctl_we,
    input  logic [1:0]            ctl_wdata,
    input  logic                  tcnt_we,
    input  logic [CNT_W-1:0]      tcnt_wdata,
    input  logic                  wptr_we,
    input  logic [DEPTH_LOG2-1:0] wptr_wdata,
    input  logic                  trace_valid,
    input  logic [2*PORT_W-1:0]   trace_data,
    input  logic                  trigger_in,
    output logic [3:0]            status,
    output logic [DEPTH_LOG2-1:0] wptr,
    output logic [CNT_W-1:0]      post_left,
    output logic                  demux_on,
    output logic                  ram_we,
    output logic [DEPTH_LOG2-1:0] ram_addr,
    output logic [2*PORT_W-1:0]   ram_wdata
);
    localparam bit SPLIT_OK = (PORT_W == 8);

    logic capturing, arm_post, post_dec, last, cfg_zero, wrap_hit, store;

    assign store = capturing && trace_valid && !ctl_we;

    trc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .run_bit(ctl_wdata[0]),
        .trigger(trigger_in), .store(store), .cfg_zero(cfg_zero), .last(last),
        .wrap_hit(wrap_hit), .capturing(capturing), .arm_post(arm_post),
        .post_dec(post_dec), .status(status)
    );

    trc_wptr #(.AW(DEPTH_LOG2)) u_wptr (
        .clk(clk), .rst_n(rst_n), .load(wptr_we), .load_val(wptr_wdata),
        .step(store), .ptr(wptr), .wrap_hit(wrap_hit)
    );

    trc_post_cnt #(.CW(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cfg_we(tcnt_we), .cfg_val(tcnt_wdata),
        .arm(arm_post), .dec(post_dec), .remain(post_left), .last(last),
        .cfg_zero(cfg_zero)
    );

    generate
        if (SPLIT_OK) begin : g_split
            logic split_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)      split_q <= 1'b0;
                else if (ctl_we) split_q <= ctl_wdata[1];
            end
            assign demux_on = split_q;
        end else begin : g_nosplit
            assign demux_on = 1'b0;
        end
    endgenerate

    assign ram_we    = store;
    assign ram_addr  = wptr;
    assign ram_wdata = demux_on ? trace_data
                                : {{PORT_W{1'b0}}, trace_data[PORT_W-1:0]};
endmodule

// File: rtl/trc_capture_chk.sv
module trc_capture_chk #(
    parameter int unsigned AW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ctl_we,
    input logic [1:0]    ctl_wdata,
    input logic          wptr_we,
    input logic [3:0]    status,
    input logic [AW-1:0] wptr,
    input logic          ram_we
);
    p_enable_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[0]) |=> (status == 4'b0000));

    p_ptr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && !wptr_we) |=> (wptr == $past(wptr) + 1'b1));

    p_ptr_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_we && !wptr_we) |=> $stable(wptr));

    p_wrap_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !(ctl_we && ctl_wdata[0])) |=> status[0]);

    p_no_store_after_acq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status[2] |-> !ram_we);

    p_drain_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[3]) |-> (status[2] && $past(status[2], 2)));

    p_stop_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && !ctl_wdata[0]) |=> (status == $past(status)));
endmodule

bind trace_capture_ctl trc_capture_chk #(.AW(DEPTH_LOG2)) u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .wptr_we(wptr_we), .status(status), .wptr(wptr), .ram_we(ram_we)
);

// File: tb/trace_capture_ctl_test.sv
module trace_capture_ctl_test;
    localparam int CLK_P = 10;
    localparam int AW = 3;
    localparam int PW = 8;
    localparam int CW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 1'b0;
    logic [1:0] ctl_wdata = '0;
    logic tcnt_we = 1'b0;
    logic [CW-1:0] tcnt_wdata = '0;
    logic wptr_we = 1'b0;
    logic [AW-1:0] wptr_wdata = '0;
    logic trace_valid = 1'b0;
    logic [2*PW-1:0] trace_data = '0;
    logic trigger_in = 1'b0;
    logic [3:0] status;
    logic [AW-1:0] wptr;
    logic [CW-1:0] post_left;
    logic demux_on, ram_we;
    logic [AW-1:0] ram_addr;
    logic [2*PW-1:0] ram_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    trace_capture_ctl #(.DEPTH_LOG2(AW), .PORT_W(PW), .CNT_W(CW)) uut (.*);

    // row: {ctl_we, ctl_d[1:0], valid, trig, exp_status[3:0], exp_wptr[2:0]}
    localparam logic [11:0] VEC [19] = '{
        {1'b1, 2'b01, 1'b0, 1'b0, 4'h0, 3'd0}, // R2 start
        {1'b0, 2'b00, 1'b1, 1'b0, 4'h0, 3'd1}, // R3
        {1'b0, 2'b00, 1'b1, 1'b0, 4'h0, 3'd2}, // R3
        {1'b0, 2'b00, 1'b0, 1'b0, 4'h0, 3'd2}, // R3 gap
        {1'b0, 2'b00, 1'b1, 1'b1, 4'h2, 3'd3}, // R5 trigger on a word
        {1'b0, 2'b00, 1'b1, 1'b0, 4'h2, 3'd4}, // R6 count 3 -> 2
        {1'b0, 2'b00, 1'b1, 1'b1, 4'h2, 3'd5}, // R5 repeat trigger ignored
        {1'b0, 2'b00, 1'b0, 1'b0, 4'h2, 3'd5}, // R6 idle not counted
        {1'b0, 2'b00, 1'b1, 1'b0, 4'h6, 3'd6}, // R6 last word, acq set
        {1'b0, 2'b00, 1'b1, 1'b0, 4'h6, 3'd6}, // R7 drain, no store
        {1'b0, 2'b00, 1'b0, 1'b0, 4'hE, 3'd6}, // R7 drained
        {1'b0, 2'b00, 1'b1, 1'b0, 4'hE, 3'd6}, // R6 no store when done
        {1'b1, 2'b01, 1'b0, 1'b0, 4'h0, 3'd6}, // R2 restart keeps ptr
        {1'b0, 2'b00, 1'b1, 1'b0, 4'h0, 3'd7}, // R3
        {1'b0, 2'b00, 1'b1, 1'b0, 4'h1, 3'd0}, // R4 wrap
        {1'b0, 2'b00, 1'b1, 1'b0, 4'h1, 3'd1}, // R4 sticky
        {1'b1, 2'b00, 1'b1, 1'b0, 4'h1, 3'd1}, // R8 stop, no store
        {1'b0, 2'b00, 1'b1, 1'b0, 4'h1, 3'd1}, // R8 idle ignores data
        {1'b0, 2'b00, 1'b0, 1'b1, 4'h1, 3'd1}  // R5 idle trigger ignored
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic quiet();
        ctl_we = 0; tcnt_we = 0; wptr_we = 0; trace_valid = 0; trigger_in = 0;
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(CLK_P * 4000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            summary();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 status", 32'(status), 0);
        check("R1 wptr", 32'(wptr), 0);
        check("R1 ram_we", 32'(ram_we), 0);
        @(negedge clk); rst_n = 1;
        tcnt_we = 1; tcnt_wdata = 8'd3;
        tick();

        for (int i = 0; i < 19; i++) begin
            @(negedge clk);
            quiet();
            {ctl_we, ctl_wdata, trace_valid, trigger_in} = VEC[i][11:7];
            trace_data = 16'(i);
            tick();
            check($sformatf("R5/R6 row %0d status", i), 32'(status), 32'(VEC[i][6:3]));
            check($sformatf("R3/R4 row %0d wptr", i), 32'(wptr), 32'(VEC[i][2:0]));
        end

        // R6 R9: zero count, trigger ends capture at once; pointer load
        @(negedge clk); quiet();
        tcnt_we = 1; tcnt_wdata = 0; wptr_we = 1; wptr_wdata = 3'd2;
        tick();
        check("R9 wptr load", 32'(wptr), 2);
        @(negedge clk); quiet(); ctl_we = 1; ctl_wdata = 2'b01; tick();
        @(negedge clk); quiet(); trace_valid = 1; trigger_in = 1; tick();
        check("R6 zero count status", 32'(status), 32'h6);
        check("R6 zero count wptr", 32'(wptr), 3);
        @(negedge clk); quiet(); trace_valid = 1; tick();
        check("R7 one cycle after acq", 32'(status), 32'h6);
        @(negedge clk); quiet(); tick();
        check("R7 two cycles after acq", 32'(status), 32'hE);

        // R9: load wins over increment
        @(negedge clk); quiet(); ctl_we = 1; ctl_wdata = 2'b01; tick();
        @(negedge clk); quiet(); trace_valid = 1; wptr_we = 1; wptr_wdata = 3'd5; tick();
        check("R9 load priority", 32'(wptr), 5);

        // R10 split-port data path, R3 same-cycle strobe and address
        @(negedge clk); quiet(); ctl_we = 1; ctl_wdata = 2'b11; tick();
        check("R10 demux_on", 32'(demux_on), 1);
        @(negedge clk); quiet(); trace_valid = 1; trace_data = 16'hA55A; #1;
        check("R3 ram_we", 32'(ram_we), 1);
        check("R3 ram_addr", 32'(ram_addr), 5);
        check("R10 split data", 32'(ram_wdata), 32'hA55A);
        tick();
        @(negedge clk); quiet(); ctl_we = 1; ctl_wdata = 2'b01; tick();
        @(negedge clk); quiet(); trace_valid = 1; trace_data = 16'hA55A; #1;
        check("R10 narrow data", 32'(ram_wdata), 32'h005A);
        tick();

        // R8 R3 R5: stop, then data and trigger have no effect
        @(negedge clk); quiet(); ctl_we = 1; ctl_wdata = 2'b00; tick();
        @(negedge clk); quiet(); trace_valid = 1; trigger_in = 1; #1;
        check("R3 idle ram_we", 32'(ram_we), 0);
        tick();
        check("R5 idle trigger", 32'(status), 0);
        check("R8 idle wptr", 32'(wptr), 7);

        finished = 1;
        summary();
    end
endmodule